// File: doc/BRIEF.md
# Extension Channel Busy Ratio Monitor

This block estimates how busy the extension channel is during the time the control channel was clear. Three counters run freely outside the block: total clock cycles, control-channel busy cycles and extension-channel busy cycles. When the `sample_i` strobe is accepted, the block subtracts the snapshot kept from the previous accepted sample from each counter. It then reports the extension busy time as a whole percentage, from 0 to 100, of the control-channel clear time. The current counter values become the new snapshot.

Ordinary cases need an integer division. A restoring divider inside the block does it, producing one quotient bit per clock. While the divider runs, `busy_o` is high and sample strobes are dropped. Cases that need no division return their result on the next cycle. These are the first sample, a cycle counter that went backwards, and a zero clear interval. Every result is marked by a one-cycle `valid_o` pulse.

Top module: `ext_busy_ratio`

## Requirements
- R1: When the stored cycle snapshot is zero, an accepted sample returns 0. This covers the first sample after reset and a previous sample taken at cycle count 0.
- R2: An accepted sample whose cycle count is below the stored cycle snapshot returns 0. A cycle count equal to the snapshot is not treated this way.
- R3: Each delta is the new counter value minus the stored snapshot, taken modulo 2^CNT_W, so a busy counter that passes its top value still gives the true small delta.
- R4: The clear interval is the cycle delta minus the control-busy delta when the cycle delta is strictly greater. Otherwise the clear interval is zero.
- R5: When the clear interval is zero and R1 and R2 do not apply, the result is 100.
- R6: Otherwise the result is floor(extension delta × 100 / clear interval), and any value above 100 is reported as 100.
- R7: Every accepted sample replaces all three snapshots with the current counter values, including in the R1, R2 and R5 cases.
- R8: An R1, R2 or R5 result appears with `valid_o` on the clock edge after the accepting edge. A divided result appears after the divider finishes. `valid_o` lasts one cycle per accepted sample.
- R9: A `sample_i` strobe while `busy_o` is high is ignored. It changes neither the snapshots nor the pending result.
- R10: `busy_o` is high from the cycle after a division case is accepted until the cycle in which its result is valid. It stays low for R1, R2 and R5 cases.
- R11: A synchronous active-high reset clears the snapshots, `result_o`, `valid_o` and `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Take a sample (accepted when `busy_o` is low) |
| cycle_cnt_i | input | CNT_W | Free-running total cycle counter |
| ctl_busy_i | input | CNT_W | Free-running control-channel busy counter |
| ext_busy_i | input | CNT_W | Free-running extension-channel busy counter |
| busy_o | output | 1 | Division in progress; samples are dropped |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | PCT_W | Extension busy percentage, 0 to 100 |

## Verification
The bench builds the block with CNT_W = 16 and the default scale of 100. The narrow counters shorten each division to 23 steps. They also let small, hand-checkable values reach the counter ceiling, so the modulo deltas of R3 and a clamped quotient far above 100 both appear within a few samples. With the scale left at 100, every expected percentage can be worked out by hand from the requirement formulas.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  // How an accepted sample is resolved.
  typedef enum logic [1:0] {
    EBR_ZERO   = 2'd0,  // no usable previous sample, or cycle counter went back
    EBR_FULL   = 2'd1,  // clear interval is zero
    EBR_DIVIDE = 2'd2   // ratio needs the sequential divider
  } ebr_path_e;
endpackage

// File: rtl/ebr_snapshot.sv
module ebr_snapshot
  import ebr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] ctl_i,
  input  logic [CNT_W-1:0] ext_i,
  output logic [CNT_W-1:0] prev_cyc_o,
  output logic [CNT_W-1:0] prev_ctl_o,
  output logic [CNT_W-1:0] clear_d_o,
  output logic [CNT_W-1:0] ext_d_o,
  output ebr_path_e        path_o
);
  logic [CNT_W-1:0] prev_cyc, prev_ctl, prev_ext;
  logic [CNT_W-1:0] cyc_d, ctl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cyc <= '0;
      prev_ctl <= '0;
      prev_ext <= '0;
    end else if (capture_i) begin
      prev_cyc <= cyc_i;
      prev_ctl <= ctl_i;
      prev_ext <= ext_i;
    end
  end

  // Modulo differences against the held snapshot.
  always_comb begin
    cyc_d   = cyc_i - prev_cyc;
    ctl_d   = ctl_i - prev_ctl;
    ext_d_o = ext_i - prev_ext;
    clear_d_o = (cyc_d > ctl_d) ? (cyc_d - ctl_d) : '0;
    if (prev_cyc == '0 || cyc_i < prev_cyc)
      path_o = EBR_ZERO;
    else if (clear_d_o == '0)
      path_o = EBR_FULL;
    else
      path_o = EBR_DIVIDE;
  end

  assign prev_cyc_o = prev_cyc;
  assign prev_ctl_o = prev_ctl;
endmodule

// File: rtl/ebr_divider.sv
module ebr_divider #(
  parameter int NUM_W = 39,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0]  acc;
  logic [DEN_W-1:0]  rem;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] steps;
  logic              busy, done;

  logic [DEN_W:0]   trial, diff;
  logic             fits;
  logic [DEN_W-1:0] rem_n;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  always_comb begin
    trial = {rem, acc[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = (trial >= {1'b0, den_q});
    rem_n = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      rem   <= '0;
      den_q <= '0;
      steps <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc   <= {acc[NUM_W-2:0], fits};
        rem   <= rem_n;
        steps <= steps - 1'b1;
        if (steps == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start_i) begin
        acc   <= num_i;
        rem   <= '0;
        den_q <= den_i;
        steps <= STEP_W'(NUM_W);
        busy  <= 1'b1;
      end
    end
  end

  assign busy_o = busy;
  assign done_o = done;
  assign quo_o  = acc;
endmodule

// File: rtl/ext_busy_ratio.sv
module ext_busy_ratio
  import ebr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCALE = 100,
  parameter int PCT_W = $clog2(SCALE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_i,
  input  logic [CNT_W-1:0] cycle_cnt_i,
  input  logic [CNT_W-1:0] ctl_busy_i,
  input  logic [CNT_W-1:0] ext_busy_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [PCT_W-1:0] result_o
);
  localparam int NUM_W = CNT_W + PCT_W;

  logic             accept;
  logic [CNT_W-1:0] prev_cyc, prev_ctl, clear_d, ext_d;
  ebr_path_e        path;
  logic [NUM_W-1:0] num, quo;
  logic             div_busy, div_done;
  logic [PCT_W-1:0] res_q, quo_pct;
  logic             val_q;

  // A finishing division also blocks samples so its result slot is free.
  assign busy_o = div_busy | div_done;
  assign accept = sample_i & ~busy_o;

  ebr_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .capture_i (accept),
    .cyc_i     (cycle_cnt_i),
    .ctl_i     (ctl_busy_i),
    .ext_i     (ext_busy_i),
    .prev_cyc_o(prev_cyc),
    .prev_ctl_o(prev_ctl),
    .clear_d_o (clear_d),
    .ext_d_o   (ext_d),
    .path_o    (path)
  );

  assign num = NUM_W'(ext_d) * NUM_W'(SCALE);

  ebr_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .start_i(accept && path == EBR_DIVIDE),
    .num_i  (num),
    .den_i  (clear_d),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo)
  );

  assign quo_pct = (quo > NUM_W'(SCALE)) ? PCT_W'(SCALE) : quo[PCT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      val_q <= 1'b0;
    end else begin
      val_q <= 1'b0;
      if (div_done) begin
        res_q <= quo_pct;
        val_q <= 1'b1;
      end else if (accept && path != EBR_DIVIDE) begin
        res_q <= (path == EBR_FULL) ? PCT_W'(SCALE) : '0;
        val_q <= 1'b1;
      end
    end
  end

  assign valid_o  = val_q;
  assign result_o = res_q;
endmodule

// File: rtl/ext_busy_ratio_chk.sv
module ext_busy_ratio_chk #(
  parameter int CNT_W = 32,
  parameter int SCALE = 100,
  parameter int PCT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_i,
  input logic [CNT_W-1:0] cycle_cnt_i,
  input logic [CNT_W-1:0] ctl_busy_i,
  input logic [CNT_W-1:0] ext_busy_i,
  input logic             busy_o,
  input logic             valid_o,
  input logic [PCT_W-1:0] result_o,
  input logic [CNT_W-1:0] prev_cyc,
  input logic [CNT_W-1:0] prev_ctl
);
  logic             take, stale;
  logic [CNT_W-1:0] c_cyc_d, c_ctl_d;
  logic             no_clear;

  always_comb begin
    take     = sample_i && !busy_o;
    stale    = (prev_cyc == '0) || (cycle_cnt_i < prev_cyc);
    c_cyc_d  = cycle_cnt_i - prev_cyc;
    c_ctl_d  = ctl_busy_i - prev_ctl;
    no_clear = !(c_cyc_d > c_ctl_d);
  end

  AST_STALE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (take && stale) |=> (valid_o && result_o == '0));                         // R1
  AST_NO_CLEAR_FULL: assert property (@(posedge clk) disable iff (rst)
    (take && !stale && no_clear) |=> (valid_o && result_o == PCT_W'(SCALE))); // R5
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (result_o <= PCT_W'(SCALE)));                                 // R6
  AST_SNAP_UPDATE: assert property (@(posedge clk) disable iff (rst)
    take |=> (prev_cyc == $past(cycle_cnt_i) && prev_ctl == $past(ctl_busy_i))); // R7
  AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (sample_i && busy_o) |=> ($stable(prev_cyc) && $stable(prev_ctl)));      // R9
  AST_DIV_BUSY: assert property (@(posedge clk) disable iff (rst)
    (take && !stale && !no_clear) |=> (busy_o && !valid_o));                  // R10
  AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !valid_o);                                                     // R10
endmodule

bind ext_busy_ratio ext_busy_ratio_chk #(
  .CNT_W(CNT_W), .SCALE(SCALE), .PCT_W(PCT_W)
) u_chk (.*);

// File: tb/ext_busy_ratio_tb.sv
module ext_busy_ratio_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SCALE = 100;
  localparam int PCT_W = $clog2(SCALE + 1);
  localparam int WATCHDOG = 20000;
  localparam int NVEC = 14;

  // Stimulus and expected results, applied in order from reset.
  localparam int V_CYC [NVEC] = '{1000, 2000, 3000, 4000, 5000, 4500, 5500,
                                  6500, 7500, 8500, 60000, 60000, 61000, 62000};
  localparam int V_CTL [NVEC] = '{100, 300, 1300, 1500, 1600, 1700, 2000,
                                  2100, 3200, 3300, 3300, 3300, 3400, 3500};
  localparam int V_EXT [NVEC] = '{50, 200, 300, 1000, 3000, 3100, 3100,
                                  3200, 3300, 4200, 65500, 65500, 164, 464};
  localparam int V_EXP [NVEC] = '{0, 18, 100, 87, 100, 0, 0,
                                  11, 100, 100, 100, 100, 22, 33};
  localparam bit V_DIV [NVEC] = '{0, 1, 0, 1, 1, 0, 1,
                                  1, 0, 1, 1, 0, 1, 1};
  localparam string V_REQ [NVEC] = '{"R1", "R6", "R5", "R6", "R6", "R2", "R7",
                                     "R6", "R4", "R6", "R6", "R2", "R3", "R3"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sample_i = 1'b0;
  logic [CNT_W-1:0] cycle_cnt_i = '0;
  logic [CNT_W-1:0] ctl_busy_i = '0;
  logic [CNT_W-1:0] ext_busy_i = '0;
  logic             busy_o, valid_o;
  logic [PCT_W-1:0] result_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ext_busy_ratio #(.CNT_W(CNT_W), .SCALE(SCALE)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .sample_i   (sample_i),
    .cycle_cnt_i(cycle_cnt_i),
    .ctl_busy_i (ctl_busy_i),
    .ext_busy_i (ext_busy_i),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .result_o   (result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobe one sample, then wait for its result and check it.
  task automatic run_sample(input int c, input int t, input int e,
                            input int exp, input bit is_div, input string req);
    int waited;
    @(negedge clk);
    cycle_cnt_i = CNT_W'(c);
    ctl_busy_i  = CNT_W'(t);
    ext_busy_i  = CNT_W'(e);
    sample_i    = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    check(busy_o == is_div, "R10", int'(busy_o), int'(is_div));
    waited = 0;
    while (!valid_o && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check(valid_o && (is_div || waited == 0), "R8", waited, 0);
    check(int'(result_o) == exp, req, int'(result_o), exp);
    @(negedge clk);
    check(!valid_o, "R8", int'(valid_o), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int waited;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!valid_o && !busy_o && result_o == '0, "R11", int'(result_o), 0);

    for (int i = 0; i < NVEC; i++)
      run_sample(V_CYC[i], V_CTL[i], V_EXT[i], V_EXP[i], V_DIV[i], V_REQ[i]);

    // Reset mid-run clears outputs and snapshots.
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(!valid_o && !busy_o && result_o == '0, "R11", int'(result_o), 0);
    run_sample(9000, 500, 500, 0, 1'b0, "R11");
    // A sample taken at cycle count 0 leaves the no-previous marker in place.
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_sample(0, 0, 0, 0, 1'b0, "R1");
    run_sample(1000, 0, 10, 0, 1'b0, "R1");

    // Strobe during a division is dropped.
    @(negedge clk);
    cycle_cnt_i = 16'd2000;
    ctl_busy_i  = 16'd100;
    ext_busy_i  = 16'd460;
    sample_i    = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    check(busy_o, "R9", int'(busy_o), 1);
    cycle_cnt_i = 16'd9000;
    ctl_busy_i  = 16'd9000;
    ext_busy_i  = 16'd9000;
    sample_i    = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    waited = 0;
    while (!valid_o && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check(valid_o && result_o == 7'd50, "R9", int'(result_o), 50);
    @(negedge clk);
    check(!valid_o, "R9", int'(valid_o), 0);
    // Deltas must still be taken against the 2000/100/460 snapshot.
    run_sample(3000, 200, 910, 50, 1'b1, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule